// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general-purpose registers of a 32-bit processor core. Sixteen architectural registers are visible at any moment, addressed by a 4-bit index. Index 13 serves as the stack pointer, 14 as the link register and 15 as the program counter. Index 15 is only stored here; any special program-counter handling lives elsewhere. Which physical storage word an index reaches depends on a 5-bit processor mode input. This lets exception handlers work on private copies of some registers without saving the interrupted program's values.

The fast-interrupt mode owns private copies of indices 8 to 14. Each of the four other privileged exception modes (interrupt, supervisor, abort, undefined) owns private copies of indices 13 and 14 only. User mode and system mode share the unbanked set. The file has two combinational read ports and one synchronous write port. All three ports are resolved through the same mode value presented in the cycle.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears every physical register to zero. Afterwards every index reads zero in every mode.
- R2: User mode (5'b10000) and system mode (5'b11111) address the same sixteen physical registers for every index.
- R3: In fast-interrupt mode (5'b10001), indices 8 to 14 reach seven private registers. Writes to them are invisible in every other mode, and other modes' values at those indices are invisible to it.
- R4: Interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes each reach a private pair for indices 13 and 14, distinct from one another and from the user pair.
- R5: Indices 0 to 7 and 15 are shared by all modes. Indices 8 to 12 are shared by every mode except fast-interrupt mode.
- R6: Any mode value outside the seven listed codes selects the user set.
- R7: When `wr_en` is high at a rising edge, `wr_data` is stored in the register selected by `wr_idx` under the mode present in that same cycle. The value is readable from the next cycle.
- R8: Reads are combinational. Reading the register being written in the same cycle returns its value from before the write.
- R9: The two read ports are independent. When both present the same index, they return the same data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 5 | Current processor mode code |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Architectural index to write |
| wr_data | input | 32 | Data to write |
| ra_idx | input | 4 | Architectural index for read port A |
| ra_data | output | 32 | Read port A data |
| rb_idx | input | 4 | Architectural index for read port B |
| rb_data | output | 32 | Read port B data |

## Verification
A write and a read of the same physical register can fall in the same cycle. The read must return the pre-write value, and the new value must appear on the following cycle. The bench provokes this with directed writes whose read index equals the write index. Random traffic also collides often, because the index space is small and one read port in four reuses the other's index. The bench judges each read against a model that is updated only after the clock edge. It separately checks that a collision across banks (same index, different modes) leaves the other bank's word untouched.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

   typedef enum logic [2:0] {
      BK_USER = 3'd0,
      BK_FAST = 3'd1,
      BK_IRQ  = 3'd2,
      BK_SUPV = 3'd3,
      BK_ABRT = 3'd4,
      BK_UNDF = 3'd5
   } bank_e;

   localparam logic [4:0] MD_USER = 5'b10000;
   localparam logic [4:0] MD_FAST = 5'b10001;
   localparam logic [4:0] MD_IRQ  = 5'b10010;
   localparam logic [4:0] MD_SUPV = 5'b10011;
   localparam logic [4:0] MD_ABRT = 5'b10111;
   localparam logic [4:0] MD_UNDF = 5'b11011;
   localparam logic [4:0] MD_SYST = 5'b11111;

   // Banks that hold a private stack/link pair, counted from BK_IRQ
   localparam int unsigned NUM_PAIR_BANKS = 4;

endpackage

// File: rtl/bankreg_mode_decode.sv
module bankreg_mode_decode
   import bankreg_pkg::*;
(
   input  logic [4:0] mode_i,
   output bank_e      bank_o
);

   always_comb begin
      unique case (mode_i)
         MD_FAST: bank_o = BK_FAST;
         MD_IRQ:  bank_o = BK_IRQ;
         MD_SUPV: bank_o = BK_SUPV;
         MD_ABRT: bank_o = BK_ABRT;
         MD_UNDF: bank_o = BK_UNDF;
         default: bank_o = BK_USER; // user, system and unknown codes
      endcase
   end

endmodule

// File: rtl/bankreg_index_map.sv
module bankreg_index_map
   import bankreg_pkg::*;
#(
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned FAST_LO = 8,
   parameter int unsigned PRIV_LO = 13,
   parameter int unsigned PW      = 5
) (
   input  bank_e             bank_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [PW-1:0]     phys_o
);

   localparam int unsigned ARCH     = 1 << IDX_W;
   localparam int unsigned TOP_IDX  = ARCH - 1;          // never banked
   localparam int unsigned FAST_CNT = TOP_IDX - FAST_LO;
   localparam int unsigned PRIV_CNT = TOP_IDX - PRIV_LO;
   localparam int unsigned FAST_BASE = ARCH;
   localparam int unsigned PAIR_BASE = ARCH + FAST_CNT;

   int unsigned idx_n;
   int unsigned bank_k;
   int unsigned phys_n;

   always_comb begin
      idx_n  = int'(idx_i);
      bank_k = int'(bank_i) - int'(BK_IRQ);
      phys_n = idx_n;
      if (bank_i == BK_FAST) begin
         if (idx_n >= FAST_LO && idx_n < TOP_IDX)
            phys_n = FAST_BASE + (idx_n - FAST_LO);
      end else if (bank_i != BK_USER) begin
         if (idx_n >= PRIV_LO && idx_n < TOP_IDX)
            phys_n = PAIR_BASE + bank_k * PRIV_CNT + (idx_n - PRIV_LO);
      end
      phys_o = PW'(phys_n);
   end

endmodule

// File: rtl/bankreg_store.sv
module bankreg_store #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PHYS   = 31,
   parameter int unsigned PW     = 5,
   parameter int unsigned NRD    = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       we,
   input  logic [PW-1:0]              waddr,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [NRD-1:0][PW-1:0]     raddr,
   output logic [NRD-1:0][DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [PHYS];

   for (genvar g = 0; g < PHYS; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (rst)
            mem[g] <= '0;
         else if (we && waddr == PW'(g))
            mem[g] <= wdata;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rdata[p] = (int'(raddr[p]) < PHYS) ? mem[raddr[p]] : '0;
   end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import bankreg_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned FAST_LO = 8,
   parameter int unsigned PRIV_LO = 13
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [4:0]        mode_i,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  ra_idx,
   output logic [DATA_W-1:0] ra_data,
   input  logic [IDX_W-1:0]  rb_idx,
   output logic [DATA_W-1:0] rb_data
);

   localparam int unsigned ARCH     = 1 << IDX_W;
   localparam int unsigned FAST_CNT = ARCH - 1 - FAST_LO;
   localparam int unsigned PRIV_CNT = ARCH - 1 - PRIV_LO;
   localparam int unsigned PHYS     = ARCH + FAST_CNT + NUM_PAIR_BANKS * PRIV_CNT;
   localparam int unsigned PW       = $clog2(PHYS);
   localparam int unsigned NPORT    = 3;   // port 0 write, 1 and 2 read

   if (DATA_W < 1)
      $error("banked_regfile: DATA_W must be at least 1");
   if (IDX_W != 4)
      $error("banked_regfile: mode codes assume sixteen architectural registers");
   if (!(FAST_LO < PRIV_LO && PRIV_LO < ARCH - 1))
      $error("banked_regfile: need FAST_LO < PRIV_LO < last index");

   bank_e bank;

   bankreg_mode_decode u_dec (
      .mode_i (mode_i),
      .bank_o (bank)
   );

   logic [NPORT-1:0][IDX_W-1:0] arch_idx;
   logic [NPORT-1:0][PW-1:0]    phys_idx;

   assign arch_idx[0] = wr_idx;
   assign arch_idx[1] = ra_idx;
   assign arch_idx[2] = rb_idx;

   for (genvar p = 0; p < NPORT; p++) begin : g_map
      bankreg_index_map #(
         .IDX_W   (IDX_W),
         .FAST_LO (FAST_LO),
         .PRIV_LO (PRIV_LO),
         .PW      (PW)
      ) u_map (
         .bank_i (bank),
         .idx_i  (arch_idx[p]),
         .phys_o (phys_idx[p])
      );
   end

   logic [1:0][DATA_W-1:0] rd_words;

   bankreg_store #(
      .DATA_W (DATA_W),
      .PHYS   (PHYS),
      .PW     (PW),
      .NRD    (2)
   ) u_store (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_en),
      .waddr (phys_idx[0]),
      .wdata (wr_data),
      .raddr (phys_idx[2:1]),
      .rdata (rd_words)
   );

   assign ra_data = rd_words[0];
   assign rb_data = rd_words[1];

endmodule

// File: rtl/banked_regfile_checker.sv
module banked_regfile_checker #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 4
) (
   input logic              clk,
   input logic              rst,
   input logic [4:0]        mode_i,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic [IDX_W-1:0]  ra_idx,
   input logic [DATA_W-1:0] ra_data,
   input logic [IDX_W-1:0]  rb_idx,
   input logic [DATA_W-1:0] rb_data
);

   logic seen = 1'b0;
   always_ff @(posedge clk) seen <= 1'b1;

   function automatic logic is_usr_sys(input logic [4:0] m);
      return (m == 5'b10000) || (m == 5'b11111);
   endfunction

   AST_RESET_CLEARS: assert property (@(posedge clk)
      seen && $past(rst) |-> (ra_data == '0 && rb_data == '0)); // R1

   AST_USER_SYSTEM_ALIAS: assert property (@(posedge clk) disable iff (rst)
      seen && !$past(rst) && $past(wr_en) && is_usr_sys($past(mode_i)) &&
      is_usr_sys(mode_i) && ra_idx == $past(wr_idx)
      |-> ra_data == $past(wr_data)); // R2

   AST_LOW_INDEX_SHARED: assert property (@(posedge clk) disable iff (rst)
      seen && !$past(rst) && $past(wr_en) &&
      ($past(wr_idx) < 4'd8 || $past(wr_idx) == 4'd15) && ra_idx == $past(wr_idx)
      |-> ra_data == $past(wr_data)); // R5

   AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
      seen && !$past(rst) && $past(wr_en) && mode_i == $past(mode_i) &&
      ra_idx == $past(wr_idx)
      |-> ra_data == $past(wr_data)); // R7

   AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
      ra_idx == rb_idx |-> ra_data == rb_data); // R9

endmodule

bind banked_regfile banked_regfile_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  mode_i = 5'b10000;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  ra_idx = '0;
   logic [31:0] ra_data;
   logic [3:0]  rb_idx = '0;
   logic [31:0] rb_data;

   int checks = 0;
   int fails  = 0;
   logic [31:0] model [31];

   always #10 clk = ~clk; // 50 MHz

   banked_regfile uut (.*);

   localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                          M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                          M_SYS = 5'b11111;

   function automatic int phys_of(input logic [4:0] m, input logic [3:0] i);
      int n = int'(i);
      case (m)
         M_FIQ: return (n >= 8 && n <= 14) ? 16 + n - 8 : n;
         M_IRQ: return (n == 13 || n == 14) ? 23 + n - 13 : n;
         M_SVC: return (n == 13 || n == 14) ? 25 + n - 13 : n;
         M_ABT: return (n == 13 || n == 14) ? 27 + n - 13 : n;
         M_UND: return (n == 13 || n == 14) ? 29 + n - 13 : n;
         default: return n;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one write cycle, model updated after the edge
   task automatic wr(input logic [4:0] m, input logic [3:0] i, input logic [31:0] d);
      @(negedge clk);
      mode_i = m; wr_en = 1'b1; wr_idx = i; wr_data = d;
      @(posedge clk);
      model[phys_of(m, i)] = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] m, input logic [3:0] i, input logic [31:0] exp,
                     input string tag);
      @(negedge clk);
      wr_en = 1'b0; mode_i = m; ra_idx = i; rb_idx = i;
      #1;
      check(tag, ra_data, exp);
      check(tag, rb_data, exp);
   endtask

   initial begin
      logic [4:0] modes [8];
      void'($urandom(32'h5eed_0011));
      modes = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS, 5'b00000};
      for (int k = 0; k < 31; k++) model[k] = '0;

      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;

      // R1: every index reads zero in every mode
      for (int m = 0; m < 8; m++)
         for (int i = 0; i < 16; i++)
            rd(modes[m], 4'(i), 32'h0, "R1 reset clear");

      // R2: user and system alias
      wr(M_USR, 4'd13, 32'hA0A0_0013);
      rd(M_SYS, 4'd13, 32'hA0A0_0013, "R2 sys sees usr r13");
      wr(M_SYS, 4'd9, 32'hB0B0_0009);
      rd(M_USR, 4'd9, 32'hB0B0_0009, "R2 usr sees sys r9");

      // R3: fast-interrupt private 8..14
      for (int i = 8; i <= 14; i++) wr(M_USR, 4'(i), 32'h1100_0000 + i);
      for (int i = 8; i <= 14; i++) wr(M_FIQ, 4'(i), 32'hF100_0000 + i);
      for (int i = 8; i <= 14; i++) rd(M_FIQ, 4'(i), 32'hF100_0000 + i, "R3 fiq private");
      for (int i = 8; i <= 14; i++) rd(M_USR, 4'(i), 32'h1100_0000 + i, "R3 usr untouched");
      rd(M_IRQ, 4'd10, 32'h1100_000A, "R3 irq sees user r10");

      // R4: four distinct stack/link pairs
      wr(M_IRQ, 4'd13, 32'h2013_0001); wr(M_SVC, 4'd13, 32'h2013_0002);
      wr(M_ABT, 4'd13, 32'h2013_0003); wr(M_UND, 4'd13, 32'h2013_0004);
      wr(M_IRQ, 4'd14, 32'h2014_0001); wr(M_UND, 4'd14, 32'h2014_0004);
      rd(M_IRQ, 4'd13, 32'h2013_0001, "R4 irq r13");
      rd(M_SVC, 4'd13, 32'h2013_0002, "R4 svc r13");
      rd(M_ABT, 4'd13, 32'h2013_0003, "R4 abt r13");
      rd(M_UND, 4'd13, 32'h2013_0004, "R4 und r13");
      rd(M_IRQ, 4'd14, 32'h2014_0001, "R4 irq r14");
      rd(M_SVC, 4'd14, 32'h0, "R4 svc r14 untouched");
      rd(M_USR, 4'd13, 32'h1100_000D, "R4 user r13 untouched");

      // R5: shared low indices and r15
      wr(M_FIQ, 4'd3, 32'h5000_0003);
      rd(M_ABT, 4'd3, 32'h5000_0003, "R5 r3 shared");
      wr(M_FIQ, 4'd15, 32'h5000_000F);
      rd(M_SVC, 4'd15, 32'h5000_000F, "R5 r15 shared");
      wr(M_SVC, 4'd12, 32'h5000_000C);
      rd(M_USR, 4'd12, 32'h5000_000C, "R5 r12 shared outside fiq");
      rd(M_FIQ, 4'd12, 32'hF100_000C, "R5 fiq r12 private");

      // R6: unknown mode uses user set
      wr(5'b00101, 4'd14, 32'h6000_000E);
      rd(M_USR, 4'd14, 32'h6000_000E, "R6 unknown mode writes user");
      rd(5'b11000, 4'd8, 32'h1100_0008, "R6 unknown mode reads user");

      // R7/R8: read during write returns old value, new value next cycle
      @(negedge clk);
      mode_i = M_SVC; wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'h8888_0E0E;
      ra_idx = 4'd14; rb_idx = 4'd14;
      #1;
      check("R8 old value during write", ra_data, 32'h0);
      @(posedge clk);
      model[phys_of(M_SVC, 4'd14)] = 32'h8888_0E0E;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      check("R7 new value next cycle", ra_data, 32'h8888_0E0E);
      rd(M_IRQ, 4'd14, 32'h2014_0001, "R7 write went to svc only");

      // R7/R8/R9: random traffic against the model
      for (int n = 0; n < 3000; n++) begin
         logic [4:0] m;
         logic       we;
         logic [3:0] wi;
         logic [31:0] wd;
         m  = ($urandom % 8 == 7) ? 5'($urandom) : modes[$urandom % 7];
         we = 1'($urandom);
         wi = 4'($urandom);
         wd = $urandom;
         @(negedge clk);
         mode_i = m; wr_en = we; wr_idx = wi; wr_data = wd;
         ra_idx = ($urandom % 3 == 0) ? wi : 4'($urandom);
         rb_idx = ($urandom % 4 == 0) ? ra_idx : 4'($urandom);
         #1;
         check("R8 random read A", ra_data, model[phys_of(m, ra_idx)]);
         check("R9 random read B", rb_data, model[phys_of(m, rb_idx)]);
         @(posedge clk);
         if (we) model[phys_of(m, wi)] = wd;
      end
      @(negedge clk);
      wr_en = 1'b0;

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule